// File: doc/BRIEF.md
# Lockstep Instruction Duplicator for Self-Consistency Checking

This unit sits in front of the decode stage of a single-issue RISC-V pipeline and is fed by an unconstrained instruction source. Each instruction it lets through as an *original* is kept in a pending queue. Later, when a free select input asks for a duplicate, the oldest pending original is issued again. In that copy every register field the instruction actually uses is moved into the upper half of the architectural register file. The original stream only touches registers 0 to 15, and the duplicate stream works on 16 to 31 in exactly the same program order. Once both streams have committed the same number of instructions, the two halves of the register file must agree. Any mismatch exposes a datapath bug without a hand-written reference model.

The select input may change every cycle, so originals and duplicates interleave in any pattern a formal tool or a random bench chooses. A downstream stall freezes the unit. When the queue is full, the unit refuses new originals. Issue is one instruction per cycle through a registered output stage. Each issued instruction carries a tag that tells the original copy from the duplicate.

Top module: `qed_dup_unit`

## Requirements
- R1: After reset, out_valid and out_is_dup are 0, and the pending queue is empty, so in_ready is 1 while out_stall is 0 and exec_dup is 0.
- R2: In a cycle with out_stall low, in_valid high and in_ready high, where no duplicate is selected, in_instr appears unchanged on out_instr one clock later with out_valid=1 and out_is_dup=0, and it is appended to the pending queue.
- R3: In a cycle with exec_dup high, out_stall low and at least one pending original, the oldest pending original is removed and issued one clock later with out_is_dup=1, and in_ready is 0 in that cycle.
- R4: Duplicates are issued in the same order in which their originals were issued.
- R5: A duplicate keeps every bit of its original except bit 4 of each register field that its opcode (bits 6:0) uses. That bit is set when the field is non-zero. The fields are rd = bits 11:7, rs1 = bits 19:15 and rs2 = bits 24:20, so the bits set are 11, 19 and 24. The field usage per opcode is: 0110011 uses rd, rs1 and rs2. 0010011, 0000011 and 1100111 use rd and rs1. 0100011 and 1100011 use rs1 and rs2. 0110111, 0010111 and 1101111 use rd. Every other opcode uses none.
- R6: A used register field equal to 0 stays 0 in the duplicate.
- R7: An instruction with opcode 0110011, including multiply (funct7 = 0000001), is duplicated with all three fields remapped.
- R8: In a cycle with exec_dup high and an empty pending queue, a valid incoming instruction is issued as an original, as in R2.
- R9: When the pending queue holds DEPTH entries (default 8) and no duplicate is selected, in_ready is 0. An instruction offered then is neither issued nor queued.
- R10: In a cycle with out_stall high, in_ready is 0, out_valid is 0 one clock later, and the pending queue is unchanged.
- R11: In a cycle with nothing accepted and nothing duplicated, out_valid is 0 one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_instr | input | 32 | Incoming instruction word |
| in_valid | input | 1 | in_instr holds an instruction |
| in_ready | output | 1 | Incoming instruction is taken this cycle if valid |
| exec_dup | input | 1 | Request to issue a duplicate this cycle |
| out_stall | input | 1 | Downstream cannot take an instruction |
| out_instr | output | 32 | Issued instruction |
| out_valid | output | 1 | out_instr was issued |
| out_is_dup | output | 1 | Issued instruction is a duplicate |

## Verification
The assertions assume that originals name only registers 0 to 15 in the fields their opcode uses. Bit 4 of a used field is therefore already clear on input, and setting it is the whole remap. The bench draws originals from the listed opcodes and clears bits 11, 19 and 24 when the opcode uses the matching field. Unused fields and immediates stay random, so R5 is checked against arbitrary bits there. The select, valid and stall inputs are random apart from directed runs that fill the queue, stall with a duplicate pending, and duplicate zero-register and multiply instructions.

// File: rtl/qed_pkg.sv
`timescale 1ns/1ps
package qed_pkg;

  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int HALF_BIT  = REG_IDX_W - 1;
  localparam int N_FIELDS  = 3;

  // usage bits: [0]=rd, [1]=rs1, [2]=rs2
  typedef logic [N_FIELDS-1:0] field_use_t;

  function automatic field_use_t opcode_field_use(input logic [6:0] op);
    field_use_t u;
    case (op)
      7'b0110011:                         u = 3'b111;
      7'b0010011, 7'b0000011, 7'b1100111: u = 3'b011;
      7'b0100011, 7'b1100011:             u = 3'b110;
      7'b0110111, 7'b0010111, 7'b1101111: u = 3'b001;
      default:                            u = 3'b000;
    endcase
    return u;
  endfunction

  function automatic logic [REG_IDX_W-1:0] to_upper_half(input logic [REG_IDX_W-1:0] idx,
                                                        input logic used);
    logic [REG_IDX_W-1:0] r;
    r = idx;
    if (used && (idx != '0)) r[HALF_BIT] = 1'b1;
    return r;
  endfunction

endpackage

// File: rtl/qed_pend_fifo.sv
`timescale 1ns/1ps
module qed_pend_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (count == '0);
  assign full  = (count == CAP);
  assign head  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= ptr_next(wr_ptr);
      if (pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);
  a_r3_no_underflow: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);
  a_r10_one_op: assert property (@(posedge clk) disable iff (!rst_n) !(push && pop));

endmodule

// File: rtl/qed_field_remap.sv
`timescale 1ns/1ps
module qed_field_remap
  import qed_pkg::*;
(
  input  logic [INSTR_W-1:0] orig,
  output logic [INSTR_W-1:0] dup
);
  localparam int FIELD_LSB [N_FIELDS] = '{7, 15, 20};

  field_use_t           use_bits;
  logic [REG_IDX_W-1:0] fld_out [N_FIELDS];

  assign use_bits = opcode_field_use(orig[6:0]);

  for (genvar g = 0; g < N_FIELDS; g++) begin : g_field
    assign fld_out[g] = to_upper_half(orig[FIELD_LSB[g] +: REG_IDX_W], use_bits[g]);
  end

  assign dup = {orig[31:25], fld_out[2], fld_out[1], orig[14:12], fld_out[0], orig[6:0]};

endmodule

// File: rtl/qed_issue_ctrl.sv
`timescale 1ns/1ps
module qed_issue_ctrl (
  input  logic exec_dup,
  input  logic in_valid,
  input  logic stall,
  input  logic q_empty,
  input  logic q_full,
  output logic sel_dup,
  output logic take_in,
  output logic do_push,
  output logic do_pop,
  output logic issue
);
  assign sel_dup = exec_dup & ~q_empty;
  assign take_in = ~stall & ~sel_dup & ~q_full;
  assign do_pop  = ~stall & sel_dup;
  assign do_push = take_in & in_valid;
  assign issue   = do_pop | do_push;
endmodule

// File: rtl/qed_dup_unit.sv
`timescale 1ns/1ps
module qed_dup_unit
  import qed_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INSTR_W-1:0] in_instr,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               exec_dup,
  input  logic               out_stall,
  output logic [INSTR_W-1:0] out_instr,
  output logic               out_valid,
  output logic               out_is_dup
);
  logic               sel_dup, do_push, do_pop, issue;
  logic               q_empty, q_full;
  logic [INSTR_W-1:0] q_head, dup_word;

  qed_issue_ctrl u_ctrl (
    .exec_dup (exec_dup),
    .in_valid (in_valid),
    .stall    (out_stall),
    .q_empty  (q_empty),
    .q_full   (q_full),
    .sel_dup  (sel_dup),
    .take_in  (in_ready),
    .do_push  (do_push),
    .do_pop   (do_pop),
    .issue    (issue)
  );

  qed_pend_fifo #(.DEPTH(DEPTH), .W(INSTR_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (do_push),
    .push_data (in_instr),
    .pop       (do_pop),
    .head      (q_head),
    .empty     (q_empty),
    .full      (q_full)
  );

  qed_field_remap u_remap (
    .orig (q_head),
    .dup  (dup_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_is_dup <= 1'b0;
      out_instr  <= '0;
    end else begin
      out_valid  <= issue;
      out_is_dup <= do_pop;
      if (issue) out_instr <= do_pop ? dup_word : in_instr;
    end
  end

  a_r10_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    out_stall |=> !out_valid);
  a_r3_dup_next: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_dup && !q_empty && !out_stall) |=> (out_valid && out_is_dup));
  a_r8_orig_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_dup && q_empty && in_valid && !out_stall) |=> (out_valid && !out_is_dup));
  a_r5_opcode_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_dup) |-> (out_instr[6:0] == $past(q_head[6:0])));
  a_r6_x0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_is_dup && ($past(q_head[11:7]) == 5'd0)) |-> (out_instr[11:7] == 5'd0));
  a_r11_tag_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_dup |-> out_valid);

endmodule

// File: tb/qed_dup_unit_tb.sv
`timescale 1ns/1ps
module qed_dup_unit_tb;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] in_instr = '0;
  logic        in_valid = 1'b0, exec_dup = 1'b0, out_stall = 1'b0;
  logic        in_ready, out_valid, out_is_dup;
  logic [31:0] out_instr;

  always #5 clk = ~clk;

  qed_dup_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_instr(in_instr), .in_valid(in_valid),
    .in_ready(in_ready), .exec_dup(exec_dup), .out_stall(out_stall),
    .out_instr(out_instr), .out_valid(out_valid), .out_is_dup(out_is_dup)
  );

  typedef struct { logic is_dup; logic [31:0] instr; string tag; } exp_t;
  exp_t        eq[$];
  logic [31:0] pend[$];
  int n_checks = 0, n_fail = 0;
  bit mon_en = 0, done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic bit uses_rd(input logic [6:0] op);
    return op inside {7'b0110011, 7'b0010011, 7'b0000011, 7'b1100111,
                      7'b0110111, 7'b0010111, 7'b1101111};
  endfunction
  function automatic bit uses_rs1(input logic [6:0] op);
    return op inside {7'b0110011, 7'b0010011, 7'b0000011, 7'b1100111,
                      7'b0100011, 7'b1100011};
  endfunction
  function automatic bit uses_rs2(input logic [6:0] op);
    return op inside {7'b0110011, 7'b0100011, 7'b1100011};
  endfunction

  function automatic logic [31:0] bench_remap(input logic [31:0] x);
    logic [31:0] r = x;
    if (uses_rd(x[6:0])  && x[11:7]  != 5'd0) r[11] = 1'b1;
    if (uses_rs1(x[6:0]) && x[19:15] != 5'd0) r[19] = 1'b1;
    if (uses_rs2(x[6:0]) && x[24:20] != 5'd0) r[24] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] gen_orig();
    logic [31:0] w = $urandom;
    case ($urandom % 10)
      0: w[6:0] = 7'b0110011;  1: w[6:0] = 7'b0010011;
      2: w[6:0] = 7'b0000011;  3: w[6:0] = 7'b1100111;
      4: w[6:0] = 7'b0100011;  5: w[6:0] = 7'b1100011;
      6: w[6:0] = 7'b0110111;  7: w[6:0] = 7'b0010111;
      8: w[6:0] = 7'b1101111;  default: w[6:0] = 7'b1110011;
    endcase
    if (uses_rd(w[6:0]))  w[11] = 1'b0;
    if (uses_rs1(w[6:0])) w[19] = 1'b0;
    if (uses_rs2(w[6:0])) w[24] = 1'b0;
    return w;
  endfunction

  // driver: applies one cycle of stimulus and records what must come out
  task automatic step(input logic [31:0] ins, input logic v, input logic d,
                      input logic s, input string tag);
    bit exp_rdy;
    logic [31:0] x;
    @(negedge clk);
    in_instr = ins; in_valid = v; exec_dup = d; out_stall = s;
    #1;
    exp_rdy = !s && !(d && pend.size() > 0) && (pend.size() < DEPTH);
    chk(in_ready == exp_rdy, tag, "in_ready", {31'd0, in_ready}, {31'd0, exp_rdy});
    if (!s) begin
      if (d && pend.size() > 0) begin
        x = pend.pop_front();
        eq.push_back('{1'b1, bench_remap(x), tag});
      end else if (v && exp_rdy) begin
        pend.push_back(ins);
        eq.push_back('{1'b0, ins, tag});
      end
    end
  endtask

  // monitor: every expected item must appear exactly one clock after its cycle
  exp_t e;
  always @(posedge clk) begin
    if (mon_en) begin
      #2;
      if (out_valid) begin
        if (eq.size() == 0) chk(1'b0, "R11", "unexpected issue", out_instr, 32'd0);
        else begin
          e = eq.pop_front();
          chk(out_instr == e.instr, e.tag, "out_instr", out_instr, e.instr);
          chk(out_is_dup == e.is_dup, e.tag, "out_is_dup",
              {31'd0, out_is_dup}, {31'd0, e.is_dup});
        end
      end else if (eq.size() != 0) begin
        e = eq.pop_front();
        chk(1'b0, e.tag, "missing issue", 32'd0, e.instr);
      end
    end
  end

  initial begin
    #500us;
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(out_valid == 1'b0, "R1", "out_valid", {31'd0, out_valid}, 32'd0);
    chk(out_is_dup == 1'b0, "R1", "out_is_dup", {31'd0, out_is_dup}, 32'd0);
    chk(in_ready == 1'b1, "R1", "in_ready", {31'd0, in_ready}, 32'd1);
    mon_en = 1;

    // R7: multiply x3 = x1 * x2, duplicate must use x19, x17, x18
    step({7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'b0110011}, 1, 0, 0, "R7");
    step(32'd0, 0, 1, 0, "R7");
    // R6: addi x0, x5, 7 keeps rd = 0
    step({12'd7, 5'd5, 3'b000, 5'd0, 7'b0010011}, 1, 0, 0, "R6");
    step(32'd0, 0, 1, 0, "R6");
    // R8: duplicate requested with an empty queue
    step(gen_orig(), 1, 1, 0, "R8");
    step(32'd0, 0, 1, 0, "R3");
    // R11: idle cycles
    step(32'hFFFF_FFFF, 0, 0, 0, "R11");
    step(32'd0, 0, 0, 0, "R11");
    // R9: fill the queue, then offer one more
    for (int i = 0; i < DEPTH; i++) step(gen_orig(), 1, 0, 0, "R2");
    step(gen_orig(), 1, 0, 0, "R9");
    step(gen_orig(), 1, 0, 0, "R9");
    // R4: drain in order
    for (int i = 0; i < DEPTH; i++) step(32'd0, 0, 1, 0, "R4");
    // R10: stall with a duplicate pending and an original offered
    step(gen_orig(), 1, 0, 0, "R2");
    for (int i = 0; i < 3; i++) step(gen_orig(), 1, 1, 1, "R10");
    step(gen_orig(), 1, 0, 1, "R10");
    step(32'd0, 0, 1, 0, "R10");
    step(32'd0, 0, 0, 0, "R11");

    // random interleaving
    for (int i = 0; i < 3000; i++) begin
      logic s, d, v;
      s = ($urandom % 100) < 20;
      d = ($urandom % 100) < 40;
      v = ($urandom % 100) < 80;
      step(gen_orig(), v, d, s, d ? "R5" : "R2");
    end
    while (pend.size() > 0) step(32'd0, 0, 1, 0, "R4");
    step(32'd0, 0, 0, 0, "R11");
    step(32'd0, 0, 0, 0, "R11");
    @(negedge clk);
    chk(eq.size() == 0, "R4", "leftover expected", eq.size(), 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule